// File: doc/BRIEF.md
# Cross-Layer Address Exchange CAM

This block sits in front of the layer-select decoder of a die-stacked memory. Every access address carries four fields: a layer, an array index within that layer, a row and a column. A small fully associative table holds exchange entries. Each entry names a layer, an array index, a row, a column, a partner layer and a flag that chooses between row swapping and column swapping. When an incoming address hits an entry, only the layer field is rewritten to the partner layer. The array index, row and column pass through untouched. A swap is therefore only ever between same-numbered rows, or same-numbered columns, of same-numbered arrays on two different dies. Swapping one row or column between two layers takes two entries, one for each direction, so that accesses from either side are redirected.

Lookup is a single-cycle parallel compare across all entries, followed by a registered output. The output carries the address, a valid strobe and a hit indicator. When several entries hit, the one with the lowest index wins.

Entries are loaded and removed through a configuration port that is run by a two-state machine:
- State `ST_READY` accepts one command per cycle: write an entry, clear an entry, or start a flush. A write is rejected when the partner layer equals the entry's own layer.
- The flush command takes the transition `ST_READY -> ST_FLUSH`. The block then stays in `ST_FLUSH`, invalidating one entry per cycle in ascending order.
- When the last entry has been invalidated, the transition `ST_FLUSH -> ST_READY` is taken.

Top module: `addr_xchg_cam`

## Requirements
- R1: After reset, `out_vld`, `out_hit`, `cfg_busy` and `cfg_err` are 0, and every entry is invalid, so every lookup passes through with `out_hit`=0.
- R2: A valid entry with `colx`=0 (row exchange) hits when the input layer, array index and row equal the entry's; the column is not compared. On a hit, `out_la` is the entry's partner layer and `out_hit`=1.
- R3: A valid entry with `colx`=1 (column exchange) hits when the input layer, array index and column equal the entry's; the row is not compared. On a hit, the layer is replaced as in R2.
- R4: When no valid entry hits, `out_la` equals the input layer and `out_hit`=0.
- R5: Array index, row and column are output unchanged in every case. `out_vld` follows `in_vld` exactly one clock later, and back-to-back lookups are accepted every cycle.
- R6: When several valid entries hit the same address, the entry with the lowest index supplies the partner layer.
- R7: `cfg_op`=1 (write) stores all fields into entry `cfg_idx` and marks it valid, unless `cfg_ml` equals `cfg_la`. A rejected write leaves the table unchanged and sets `cfg_err` to 1 from the next cycle. An accepted write sets `cfg_err` to 0.
- R8: `cfg_op`=2 (clear) invalidates entry `cfg_idx`; later lookups to it miss.
- R9: `cfg_op`=3 (flush) holds `cfg_busy` high for exactly DEPTH cycles and invalidates every entry. Commands issued while busy are ignored and leave `cfg_err` unchanged. Lookups keep running during a flush.
- R10: A lookup issued in the same cycle as a write sees the table as it was before that write. The new entry is used from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Lookup request strobe |
| in_la | input | LW | Input layer |
| in_ai | input | AW | Input array index |
| in_ra | input | RW | Input row |
| in_ca | input | CW | Input column |
| out_vld | output | 1 | Registered result strobe |
| out_hit | output | 1 | An entry matched |
| out_la | output | LW | Output (possibly swapped) layer |
| out_ai | output | AW | Array index, passed through |
| out_ra | output | RW | Row, passed through |
| out_ca | output | CW | Column, passed through |
| cfg_op | input | 2 | 0 none, 1 write, 2 clear, 3 flush |
| cfg_idx | input | IW | Entry index for write and clear |
| cfg_la | input | LW | Entry layer |
| cfg_ai | input | AW | Entry array index |
| cfg_ra | input | RW | Entry row |
| cfg_ca | input | CW | Entry column |
| cfg_ml | input | LW | Entry partner layer |
| cfg_colx | input | 1 | 0 row exchange, 1 column exchange |
| cfg_busy | output | 1 | Flush in progress |
| cfg_err | output | 1 | Last write was rejected |

## Verification
The bench builds the block with its default parameters: 8 layers, 64 arrays, 1024 rows and columns, and 32 entries. The full 3-bit layer field lets paired swap entries and distinct partner layers be told apart in every result. The 32-entry depth places priority contests at scattered indices and makes the flush walk long enough to inject commands and lookups in the middle of it. The 10-bit row and column fields let near-miss addresses be built that differ in only the one field an entry ignores, or in only the one field it compares.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_CLEAR = 2'd2,
        OP_FLUSH = 2'd3
    } cfg_op_e;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_FLUSH = 1'b1
    } cfg_state_e;

endpackage

// File: rtl/xchg_entry.sv
module xchg_entry #(
    parameter int LW = 3,
    parameter int AW = 6,
    parameter int RW = 10,
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          clr_en,
    input  logic [LW-1:0] w_la,
    input  logic [AW-1:0] w_ai,
    input  logic [RW-1:0] w_ra,
    input  logic [CW-1:0] w_ca,
    input  logic [LW-1:0] w_ml,
    input  logic          w_colx,
    input  logic [LW-1:0] q_la,
    input  logic [AW-1:0] q_ai,
    input  logic [RW-1:0] q_ra,
    input  logic [CW-1:0] q_ca,
    output logic          match,
    output logic [LW-1:0] ml
);

    logic          e_vld;
    logic [LW-1:0] e_la;
    logic [AW-1:0] e_ai;
    logic [RW-1:0] e_ra;
    logic [CW-1:0] e_ca;
    logic [LW-1:0] e_ml;
    logic          e_colx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_vld  <= 1'b0;
            e_la   <= '0;
            e_ai   <= '0;
            e_ra   <= '0;
            e_ca   <= '0;
            e_ml   <= '0;
            e_colx <= 1'b0;
        end else if (wr_en) begin
            e_vld  <= 1'b1;
            e_la   <= w_la;
            e_ai   <= w_ai;
            e_ra   <= w_ra;
            e_ca   <= w_ca;
            e_ml   <= w_ml;
            e_colx <= w_colx;
        end else if (clr_en) begin
            e_vld  <= 1'b0;
        end
    end

    // Row entries compare the row, column entries compare the column.
    logic line_eq;
    always_comb begin
        line_eq = e_colx ? (e_ca == q_ca) : (e_ra == q_ra);
        match   = e_vld && (e_la == q_la) && (e_ai == q_ai) && line_eq;
        ml      = e_ml;
    end

    // R7: a stored entry never points at its own layer
    p_ml_differs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        e_vld |-> (e_ml != e_la));

    // R7/R8: write and clear are never requested together for one entry
    p_wr_clr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && clr_en));

endmodule

// File: rtl/xchg_prio.sv
module xchg_prio #(
    parameter int DEPTH = 32,
    parameter int LW    = 3
) (
    input  logic [DEPTH-1:0]         match,
    input  logic [DEPTH-1:0][LW-1:0] ml,
    output logic                     hit,
    output logic [LW-1:0]            sel_ml
);

    // Scanning downward lets the lowest matching index be assigned last.
    always_comb begin
        hit    = 1'b0;
        sel_ml = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (match[k]) begin
                hit    = 1'b1;
                sel_ml = ml[k];
            end
        end
    end

endmodule

// File: rtl/xchg_cfg_fsm.sv
module xchg_cfg_fsm
    import xchg_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LW    = 3,
    parameter int IW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cfg_op_e       op,
    input  logic [LW-1:0] la,
    input  logic [LW-1:0] ml,
    output logic          wr_go,
    output logic          clr_go,
    output logic          flush_go,
    output logic [IW-1:0] flush_idx,
    output logic          busy,
    output logic          err
);

    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    cfg_state_e    state_q, state_d;
    logic [IW-1:0] cnt_q;
    logic          err_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: if (op == OP_FLUSH) state_d = ST_FLUSH;
            ST_FLUSH: if (cnt_q == LAST)  state_d = ST_READY;
            default:  state_d = ST_READY;
        endcase
    end

    // State register with walk counter and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_READY: begin
                    cnt_q <= '0;
                    if (op == OP_WRITE) err_q <= (la == ml);
                end
                ST_FLUSH: cnt_q <= cnt_q + 1'b1;
                default:  cnt_q <= '0;
            endcase
        end
    end

    // Output decode
    always_comb begin
        wr_go     = 1'b0;
        clr_go    = 1'b0;
        flush_go  = 1'b0;
        busy      = 1'b0;
        flush_idx = cnt_q;
        unique case (state_q)
            ST_READY: begin
                wr_go  = (op == OP_WRITE) && (la != ml);
                clr_go = (op == OP_CLEAR);
            end
            ST_FLUSH: begin
                flush_go = 1'b1;
                busy     = 1'b1;
            end
            default: ;
        endcase
        err = err_q;
    end

    // R7: a self-pointing write raises the error flag one cycle later
    p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op == OP_WRITE && la == ml) |=> err);

    // R9: commands arriving during a flush leave the error flag alone
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op != OP_NONE) |=> $stable(err));

    // R9: a flush always begins at entry zero
    p_flush_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (flush_idx == '0));

endmodule

// File: rtl/addr_xchg_cam.sv
module addr_xchg_cam
    import xchg_pkg::*;
#(
    parameter int N_LAYERS = 8,
    parameter int N_ARRAYS = 64,
    parameter int N_ROWS   = 1024,
    parameter int N_COLS   = 1024,
    parameter int DEPTH    = 32,
    localparam int LW = (N_LAYERS > 1) ? $clog2(N_LAYERS) : 1,
    localparam int AW = (N_ARRAYS > 1) ? $clog2(N_ARRAYS) : 1,
    localparam int RW = (N_ROWS   > 1) ? $clog2(N_ROWS)   : 1,
    localparam int CW = (N_COLS   > 1) ? $clog2(N_COLS)   : 1,
    localparam int IW = (DEPTH    > 1) ? $clog2(DEPTH)    : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [LW-1:0] in_la,
    input  logic [AW-1:0] in_ai,
    input  logic [RW-1:0] in_ra,
    input  logic [CW-1:0] in_ca,
    output logic          out_vld,
    output logic          out_hit,
    output logic [LW-1:0] out_la,
    output logic [AW-1:0] out_ai,
    output logic [RW-1:0] out_ra,
    output logic [CW-1:0] out_ca,
    input  logic [1:0]    cfg_op,
    input  logic [IW-1:0] cfg_idx,
    input  logic [LW-1:0] cfg_la,
    input  logic [AW-1:0] cfg_ai,
    input  logic [RW-1:0] cfg_ra,
    input  logic [CW-1:0] cfg_ca,
    input  logic [LW-1:0] cfg_ml,
    input  logic          cfg_colx,
    output logic          cfg_busy,
    output logic          cfg_err
);

    logic          wr_go, clr_go, flush_go;
    logic [IW-1:0] flush_idx;

    xchg_cfg_fsm #(.DEPTH(DEPTH), .LW(LW), .IW(IW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (cfg_op_e'(cfg_op)),
        .la        (cfg_la),
        .ml        (cfg_ml),
        .wr_go     (wr_go),
        .clr_go    (clr_go),
        .flush_go  (flush_go),
        .flush_idx (flush_idx),
        .busy      (cfg_busy),
        .err       (cfg_err)
    );

    logic [DEPTH-1:0]         match;
    logic [DEPTH-1:0][LW-1:0] ent_ml;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic wr_i, clr_i;
        assign wr_i  = wr_go && (cfg_idx == IW'(g));
        assign clr_i = (clr_go && (cfg_idx == IW'(g))) ||
                       (flush_go && (flush_idx == IW'(g)));

        xchg_entry #(.LW(LW), .AW(AW), .RW(RW), .CW(CW)) u_ent (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_i),
            .clr_en (clr_i),
            .w_la   (cfg_la),
            .w_ai   (cfg_ai),
            .w_ra   (cfg_ra),
            .w_ca   (cfg_ca),
            .w_ml   (cfg_ml),
            .w_colx (cfg_colx),
            .q_la   (in_la),
            .q_ai   (in_ai),
            .q_ra   (in_ra),
            .q_ca   (in_ca),
            .match  (match[g]),
            .ml     (ent_ml[g])
        );
    end

    logic          any_hit;
    logic [LW-1:0] hit_ml;

    xchg_prio #(.DEPTH(DEPTH), .LW(LW)) u_prio (
        .match  (match),
        .ml     (ent_ml),
        .hit    (any_hit),
        .sel_ml (hit_ml)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_hit <= 1'b0;
            out_la  <= '0;
            out_ai  <= '0;
            out_ra  <= '0;
            out_ca  <= '0;
        end else begin
            out_vld <= in_vld;
            out_hit <= in_vld && any_hit;
            out_la  <= any_hit ? hit_ml : in_la;
            out_ai  <= in_ai;
            out_ra  <= in_ra;
            out_ca  <= in_ca;
        end
    end

    // R5: one-cycle result latency
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == $past(in_vld));

    // R5: non-layer fields are carried through untouched
    p_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_ai == $past(in_ai) && out_ra == $past(in_ra) &&
                     out_ca == $past(in_ca)));

    // R4: a miss leaves the layer alone
    p_miss_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_hit) |-> (out_la == $past(in_la)));

    // R2: a hit always moves the access to a different layer
    p_hit_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_hit) |-> (out_la != $past(in_la)));

    // R1: no hit is reported without a result strobe
    p_hit_needs_vld_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> !out_hit);

endmodule

// File: tb/test_addr_xchg_cam.sv
`timescale 1ns/1ps
module test_addr_xchg_cam;

    localparam int LW = 3, AW = 6, RW = 10, CW = 10, IW = 5, DEPTH = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic [LW-1:0] in_la = '0;
    logic [AW-1:0] in_ai = '0;
    logic [RW-1:0] in_ra = '0;
    logic [CW-1:0] in_ca = '0;
    logic          out_vld, out_hit;
    logic [LW-1:0] out_la;
    logic [AW-1:0] out_ai;
    logic [RW-1:0] out_ra;
    logic [CW-1:0] out_ca;
    logic [1:0]    cfg_op = 2'd0;
    logic [IW-1:0] cfg_idx = '0;
    logic [LW-1:0] cfg_la = '0;
    logic [AW-1:0] cfg_ai = '0;
    logic [RW-1:0] cfg_ra = '0;
    logic [CW-1:0] cfg_ca = '0;
    logic [LW-1:0] cfg_ml = '0;
    logic          cfg_colx = 1'b0;
    logic          cfg_busy, cfg_err;

    always #5 clk = ~clk;

    addr_xchg_cam i_addr_xchg_cam (.*);

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Reference table built from the requirements
    bit          m_v    [DEPTH];
    logic [LW-1:0] m_la [DEPTH];
    logic [AW-1:0] m_ai [DEPTH];
    logic [RW-1:0] m_ra [DEPTH];
    logic [CW-1:0] m_ca [DEPTH];
    logic [LW-1:0] m_ml [DEPTH];
    bit          m_cx   [DEPTH];

    typedef struct {
        logic [LW-1:0] la;
        logic [AW-1:0] ai;
        logic [RW-1:0] ra;
        logic [CW-1:0] ca;
        logic          hit;
        string         tag;
    } exp_t;

    exp_t expq[$];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic exp_t predict(logic [LW-1:0] la, logic [AW-1:0] ai,
                                     logic [RW-1:0] ra, logic [CW-1:0] ca, string tag);
        exp_t e;
        e.la = la; e.ai = ai; e.ra = ra; e.ca = ca; e.hit = 1'b0; e.tag = tag;
        for (int k = 0; k < DEPTH; k++) begin
            if (m_v[k] && m_la[k] == la && m_ai[k] == ai &&
                (m_cx[k] ? (m_ca[k] == ca) : (m_ra[k] == ra))) begin
                e.la = m_ml[k]; e.hit = 1'b1;
                break;
            end
        end
        return e;
    endfunction

    // Monitor: compare each result against the scoreboard queue
    always @(posedge clk) begin
        #1;
        if (rst_n && out_vld) begin
            if (expq.size() == 0) begin
                check("R5 unexpected result", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check({e.tag, " hit"}, {31'd0, out_hit}, {31'd0, e.hit});
                check({e.tag, " layer"}, 32'(out_la), 32'(e.la));
                check("R5 fields", {out_ai, out_ra, out_ca}, {e.ai, e.ra, e.ca});
            end
        end
    end

    task automatic drive_lookup(logic [LW-1:0] la, logic [AW-1:0] ai,
                                logic [RW-1:0] ra, logic [CW-1:0] ca, string tag);
        expq.push_back(predict(la, ai, ra, ca, tag));
        in_vld = 1'b1; in_la = la; in_ai = ai; in_ra = ra; in_ca = ca;
    endtask

    task automatic lookup(logic [LW-1:0] la, logic [AW-1:0] ai,
                          logic [RW-1:0] ra, logic [CW-1:0] ca, string tag);
        drive_lookup(la, ai, ra, ca, tag);
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic drive_cfg(logic [1:0] op, int idx, logic [LW-1:0] la,
                             logic [AW-1:0] ai, logic [RW-1:0] ra, logic [CW-1:0] ca,
                             logic [LW-1:0] ml, bit cx, bit busy_now);
        cfg_op = op; cfg_idx = IW'(idx); cfg_la = la; cfg_ai = ai;
        cfg_ra = ra; cfg_ca = ca; cfg_ml = ml; cfg_colx = cx;
        if (!busy_now) begin
            if (op == 2'd1 && la != ml) begin
                m_v[idx] = 1'b1; m_la[idx] = la; m_ai[idx] = ai; m_ra[idx] = ra;
                m_ca[idx] = ca; m_ml[idx] = ml; m_cx[idx] = cx;
            end else if (op == 2'd2) begin
                m_v[idx] = 1'b0;
            end
        end
    endtask

    task automatic cfg(logic [1:0] op, int idx, logic [LW-1:0] la, logic [AW-1:0] ai,
                       logic [RW-1:0] ra, logic [CW-1:0] ca, logic [LW-1:0] ml, bit cx);
        drive_cfg(op, idx, la, ai, ra, ca, ml, cx, 1'b0);
        @(negedge clk);
        cfg_op = 2'd0;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < DEPTH; k++) m_v[k] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 out_vld", {31'd0, out_vld}, 32'd0);
        check("R1 out_hit", {31'd0, out_hit}, 32'd0);
        check("R1 cfg_busy", {31'd0, cfg_busy}, 32'd0);
        check("R1 cfg_err", {31'd0, cfg_err}, 32'd0);
        lookup(3'd2, 6'd5, 10'h010, 10'h007, "R1 empty table");

        // R2: row exchange pair between layers 2 and 1
        cfg(2'd1, 0, 3'd2, 6'd5, 10'h010, 10'h3FF, 3'd1, 1'b0);
        cfg(2'd1, 1, 3'd1, 6'd5, 10'h010, 10'h000, 3'd2, 1'b0);
        lookup(3'd2, 6'd5, 10'h010, 10'h007, "R2 row hit, column ignored");
        lookup(3'd1, 6'd5, 10'h010, 10'h123, "R2 reverse direction");
        lookup(3'd2, 6'd5, 10'h011, 10'h3FF, "R4 row differs");
        lookup(3'd3, 6'd5, 10'h010, 10'h007, "R4 layer differs");
        lookup(3'd2, 6'd6, 10'h010, 10'h007, "R4 array differs");

        // R3: column exchange
        cfg(2'd1, 3, 3'd4, 6'd9, 10'h2AA, 10'h03A, 3'd6, 1'b1);
        lookup(3'd4, 6'd9, 10'h155, 10'h03A, "R3 column hit, row ignored");
        lookup(3'd4, 6'd9, 10'h2AA, 10'h03B, "R3 column differs");

        // R6: overlapping entries, lowest index wins
        cfg(2'd1, 10, 3'd0, 6'd1, 10'h002, 10'h000, 3'd7, 1'b0);
        cfg(2'd1, 5,  3'd0, 6'd1, 10'h002, 10'h000, 3'd3, 1'b0);
        cfg(2'd1, 4,  3'd0, 6'd1, 10'h000, 10'h007, 3'd5, 1'b1);
        lookup(3'd0, 6'd1, 10'h002, 10'h007, "R6 entry 4 over 5 and 10");
        lookup(3'd0, 6'd1, 10'h002, 10'h008, "R6 entry 5 over 10");
        cfg(2'd2, 5, 3'd0, 6'd0, 10'h0, 10'h0, 3'd0, 1'b0);
        lookup(3'd0, 6'd1, 10'h002, 10'h008, "R6 entry 10 after clearing 5");

        // R5: streaming lookups every cycle
        drive_lookup(3'd2, 6'd5, 10'h010, 10'h001, "R5 stream a");
        @(negedge clk);
        drive_lookup(3'd7, 6'd63, 10'h3FF, 10'h3FF, "R5 stream b");
        @(negedge clk);
        drive_lookup(3'd4, 6'd9, 10'h000, 10'h03A, "R5 stream c");
        @(negedge clk);
        in_vld = 1'b0;

        // R7: rejected write
        cfg(2'd1, 6, 3'd3, 6'd2, 10'h044, 10'h0, 3'd3, 1'b0);
        check("R7 err set", {31'd0, cfg_err}, 32'd1);
        lookup(3'd3, 6'd2, 10'h044, 10'h0, "R7 rejected entry not stored");
        cfg(2'd1, 7, 3'd3, 6'd2, 10'h045, 10'h0, 3'd4, 1'b0);
        check("R7 err cleared", {31'd0, cfg_err}, 32'd0);
        lookup(3'd3, 6'd2, 10'h045, 10'h0, "R7 accepted entry");

        // R8: clear one entry
        cfg(2'd2, 0, 3'd0, 6'd0, 10'h0, 10'h0, 3'd0, 1'b0);
        lookup(3'd2, 6'd5, 10'h010, 10'h0, "R8 cleared entry misses");
        lookup(3'd1, 6'd5, 10'h010, 10'h0, "R8 partner entry kept");

        // R10: write and lookup in the same cycle
        drive_lookup(3'd5, 6'd12, 10'h0AB, 10'h0, "R10 same cycle sees old table");
        drive_cfg(2'd1, 12, 3'd5, 6'd12, 10'h0AB, 10'h0, 3'd2, 1'b0, 1'b0);
        @(negedge clk);
        cfg_op = 2'd0;
        in_vld = 1'b0;
        lookup(3'd5, 6'd12, 10'h0AB, 10'h0, "R10 next cycle sees new entry");

        // R9: flush walk
        begin
            int busy_cycles;
            busy_cycles = 0;
            cfg(2'd3, 0, 3'd0, 6'd0, 10'h0, 10'h0, 3'd0, 1'b0);
            for (int n = 0; n < DEPTH + 4; n++) begin
                if (cfg_busy) busy_cycles++;
                cfg_op = 2'd0;
                in_vld = 1'b0;
                if (n == 2) drive_cfg(2'd1, 20, 3'd5, 6'd3, 10'h001, 10'h0, 3'd6, 1'b0, 1'b1);
                if (n == 3) drive_cfg(2'd1, 21, 3'd6, 6'd3, 10'h001, 10'h0, 3'd6, 1'b0, 1'b1);
                if (n == 4) drive_lookup(3'd7, 6'd63, 10'h3FE, 10'h3FE, "R9 lookup during flush");
                if (n == 5) check("R9 err unchanged while busy", {31'd0, cfg_err}, 32'd0);
                @(negedge clk);
            end
            check("R9 busy length", 32'(busy_cycles), 32'(DEPTH));
            for (int k = 0; k < DEPTH; k++) m_v[k] = 1'b0;
        end
        lookup(3'd1, 6'd5, 10'h010, 10'h0, "R9 entry 1 flushed");
        lookup(3'd4, 6'd9, 10'h000, 10'h03A, "R9 entry 3 flushed");
        lookup(3'd5, 6'd12, 10'h0AB, 10'h0, "R9 entry 12 flushed");
        lookup(3'd5, 6'd3, 10'h001, 10'h0, "R9 write during flush ignored");

        repeat (3) @(negedge clk);
        check("R5 all results seen", 32'(expq.size()), 32'd0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule